// File: doc/BRIEF.md
# Triple-Port Scratchpad Memory Bank

This block is a 4 KB on-chip scratchpad bank that three masters share. A dedicated 16-bit port moves halfwords for a signal-processing datapath. Two 32-bit system ports serve the processor data bus and the DMA data bus. Each system port can move a byte, a halfword or a word. Every access is accepted in the clock it is presented. Read data returns one clock later. There are no wait states.

The bank answers only inside a fixed address window set by a base parameter. A second bank is a copy of this block with a different base. The two wide ports share one physical port of the storage, and the processor wins when both present in-window requests. The narrow port has its own physical port of a dual-port array, so it never stalls. While the low-power hold input is high, every request is ignored and the array is left as it was. No reset clears the array.

Top module: `scratchpad_bank`

## Requirements
- R1: A wide-port request responds only when its address lies in BASE_ADDR to BASE_ADDR+4095 (default 0xFFFF8000 to 0xFFFF8FFF). Outside that window the request writes nothing and raises neither rvalid nor err.
- R2: An accepted, aligned wide read raises rvalid exactly one clock after the request, with the data in rdata in that same cycle. A write accepted in one cycle is visible to a read issued in the next cycle.
- R3: The size code is 0 for a byte, 1 for a halfword and 2 for a word. Lanes are big-endian: byte offset p (address bits 1:0) uses data bits 31-8p down to 24-8p, for both write data and read data. Lanes not selected by a sub-word read return zero.
- R4: A halfword with address bit 0 set, a word with address bits 1:0 not zero, and size code 3 are all misaligned. A misaligned request writes nothing, raises err one clock later and does not raise rvalid.
- R5: When both wide ports present in-window requests in the same cycle and hold is low, the processor port is served and dma_stall is high combinationally in that cycle. dma_stall is low at all other times.
- R6: A stalled DMA request writes nothing and raises neither dma_rvalid nor dma_err.
- R7: The narrow port addresses halfwords by index. An even index maps to bits 31:16 of word index/2, and an odd index maps to bits 15:0. A narrow read raises nar_rvalid one clock later, whatever the wide ports are doing.
- R8: When a narrow write and a wide write hit the same byte in the same cycle, the narrow data is stored. The wide write's other bytes are still stored.
- R9: A read in the same cycle as a write to the same location, from any port, returns the contents from before that write.
- R10: While hold_i is high, all requests on all three ports are ignored. Nothing is written, no rvalid or err is raised, dma_stall is low, and earlier contents are kept.
- R11: Reset clears every rvalid and err flag and zeroes every rdata, but does not touch the array. Between valid reads, each rdata output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the response flags and read-data registers |
| hold_i | input | 1 | Low-power hold: ignore all requests, keep contents |
| nar_req | input | 1 | Narrow port request |
| nar_we | input | 1 | Narrow port write enable |
| nar_idx | input | 11 | Narrow port halfword index |
| nar_wdata | input | 16 | Narrow port write data |
| nar_rvalid | output | 1 | Narrow read data valid |
| nar_rdata | output | 16 | Narrow read data |
| cpu_req | input | 1 | Processor port request |
| cpu_we | input | 1 | Processor port write enable |
| cpu_size | input | 2 | Processor access size code |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data, lane-positioned |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_err | output | 1 | Processor misaligned access flag |
| cpu_rdata | output | 32 | Processor read data, lane-positioned |
| dma_req | input | 1 | DMA port request |
| dma_we | input | 1 | DMA port write enable |
| dma_size | input | 2 | DMA access size code |
| dma_addr | input | 32 | DMA byte address |
| dma_wdata | input | 32 | DMA write data, lane-positioned |
| dma_stall | output | 1 | DMA request lost arbitration this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_err | output | 1 | DMA misaligned access flag |
| dma_rdata | output | 32 | DMA read data, lane-positioned |

## Verification
A wrong byte-enable or a wrong lane mux does not show in the cycle of the write. It shows at the first later read of that word from any port. So the model follows every byte and checks each port's read data on the clock after each read. A wrong grant or response flag shows in the same cycle as dma_stall, or one clock later as a wrong rvalid or err. Collisions are made likely by keeping many random addresses in a small region where all three ports overlap.

// File: rtl/spad_pkg.sv
`timescale 1ns/1ps
package spad_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Lane enables, bit 3 = data bits 31:24 (byte offset 0, big-endian).
  function automatic logic [3:0] lanes_for(input logic [1:0] off, input acc_size_e sz);
    logic [3:0] m;
    unique case (sz)
      SZ_BYTE: m = 4'b1000 >> off;
      SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
      SZ_WORD: m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  function automatic logic is_misaligned(input logic [1:0] off, input acc_size_e sz);
    logic r;
    unique case (sz)
      SZ_BYTE: r = 1'b0;
      SZ_HALF: r = off[0];
      SZ_WORD: r = |off;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] lanes_to_bits(input logic [3:0] be);
    logic [31:0] b;
    for (int j = 0; j < 4; j++) b[8*j +: 8] = {8{be[j]}};
    return b;
  endfunction

  // Narrow halfword placement: even index -> upper half of the word.
  function automatic logic [3:0] half_lanes(input logic odd);
    return odd ? 4'b0011 : 4'b1100;
  endfunction

endpackage

// File: rtl/spad_decode.sv
`timescale 1ns/1ps
module spad_decode
  import spad_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'hFFFF8000,
  parameter int          BANK_BYTES = 4096,
  parameter int          IDX_W      = 10
) (
  input  logic             req,
  input  logic             hold,
  input  acc_size_e        size,
  input  logic [31:0]      addr,
  output logic             hit,
  output logic             bad,
  output logic [IDX_W-1:0] idx,
  output logic [3:0]       be
);
  logic [31:0] off;
  logic        in_win;

  assign off    = addr - BASE_ADDR;
  assign in_win = off < 32'(BANK_BYTES);
  assign hit    = req && !hold && in_win;
  assign bad    = hit && is_misaligned(off[1:0], size);
  assign idx    = off[IDX_W+1:2];
  assign be     = lanes_for(off[1:0], size);
endmodule

// File: rtl/spad_arbiter.sv
`timescale 1ns/1ps
module spad_arbiter (
  input  logic p_hit,
  input  logic m_hit,
  output logic p_gnt,
  output logic m_gnt,
  output logic m_stall
);
  assign p_gnt   = p_hit;
  assign m_gnt   = m_hit && !p_hit;
  assign m_stall = m_hit && p_hit;
endmodule

// File: rtl/spad_array.sv
`timescale 1ns/1ps
module spad_array #(
  parameter int WORDS = 1024,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_wr,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [3:0]       a_be,
  input  logic [31:0]      a_wdata,
  output logic [31:0]      a_q,
  input  logic             b_en,
  input  logic             b_wr,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [3:0]       b_be,
  input  logic [31:0]      b_wdata,
  output logic [31:0]      b_q
);
  logic [31:0] mem [WORDS];

  // Reads see pre-write contents; port B lane writes are ordered last so
  // they win a same-byte collision.
  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_idx];
    if (b_en) b_q <= mem[b_idx];
    for (int j = 0; j < 4; j++) begin
      if (a_wr && a_be[j]) mem[a_idx][8*j +: 8] <= a_wdata[8*j +: 8];
    end
    for (int j = 0; j < 4; j++) begin
      if (b_wr && b_be[j]) mem[b_idx][8*j +: 8] <= b_wdata[8*j +: 8];
    end
  end
endmodule

// File: rtl/scratchpad_bank.sv
`timescale 1ns/1ps
module scratchpad_bank
  import spad_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'hFFFF8000,
  parameter int          BANK_BYTES = 4096,
  parameter int          HIDX_W     = $clog2(BANK_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              nar_req,
  input  logic              nar_we,
  input  logic [HIDX_W-1:0] nar_idx,
  input  logic [15:0]       nar_wdata,
  output logic              nar_rvalid,
  output logic [15:0]       nar_rdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_rvalid,
  output logic              cpu_err,
  output logic [31:0]       cpu_rdata,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [1:0]        dma_size,
  input  logic [31:0]       dma_addr,
  input  logic [31:0]       dma_wdata,
  output logic              dma_stall,
  output logic              dma_rvalid,
  output logic              dma_err,
  output logic [31:0]       dma_rdata
);
  localparam int WORDS = BANK_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);

  // Decode outputs, one set per wide port.
  logic             cpu_hit, cpu_bad, dma_hit, dma_bad;
  logic [IDX_W-1:0] cpu_idx, dma_idx;
  logic [3:0]       cpu_be, dma_be;

  spad_decode #(.BASE_ADDR(BASE_ADDR), .BANK_BYTES(BANK_BYTES), .IDX_W(IDX_W)) u_dec_cpu (
    .req(cpu_req), .hold(hold_i), .size(acc_size_e'(cpu_size)), .addr(cpu_addr),
    .hit(cpu_hit), .bad(cpu_bad), .idx(cpu_idx), .be(cpu_be));

  spad_decode #(.BASE_ADDR(BASE_ADDR), .BANK_BYTES(BANK_BYTES), .IDX_W(IDX_W)) u_dec_dma (
    .req(dma_req), .hold(hold_i), .size(acc_size_e'(dma_size)), .addr(dma_addr),
    .hit(dma_hit), .bad(dma_bad), .idx(dma_idx), .be(dma_be));

  // Arbitration between the two wide ports.
  logic cpu_gnt, dma_gnt;
  spad_arbiter u_arb (
    .p_hit(cpu_hit), .m_hit(dma_hit),
    .p_gnt(cpu_gnt), .m_gnt(dma_gnt), .m_stall(dma_stall));

  // Named internal events.
  logic cpu_go, dma_go, cpu_rd_go, dma_rd_go, cpu_bad_ev, dma_bad_ev;
  assign cpu_go     = cpu_gnt && !cpu_bad;
  assign dma_go     = dma_gnt && !dma_bad;
  assign cpu_rd_go  = cpu_go && !cpu_we;
  assign dma_rd_go  = dma_go && !dma_we;
  assign cpu_bad_ev = cpu_gnt && cpu_bad;
  assign dma_bad_ev = dma_gnt && dma_bad;

  // Wide physical port A mux.
  logic             a_en, a_wr;
  logic [IDX_W-1:0] a_idx;
  logic [3:0]       a_be;
  logic [31:0]      a_wdata, a_q;

  assign a_en    = cpu_go || dma_go;
  assign a_wr    = cpu_go ? cpu_we : (dma_go && dma_we);
  assign a_idx   = cpu_go ? cpu_idx : dma_idx;
  assign a_be    = cpu_go ? cpu_be : dma_be;
  assign a_wdata = cpu_go ? cpu_wdata : dma_wdata;

  // Narrow physical port B.
  logic              nar_go, b_wr;
  logic [IDX_W-1:0]  b_idx;
  logic [3:0]        b_be;
  logic [31:0]       b_wdata, b_q;

  assign nar_go  = nar_req && !hold_i;
  assign b_wr    = nar_go && nar_we;
  assign b_idx   = nar_idx[HIDX_W-1:1];
  assign b_be    = half_lanes(nar_idx[0]);
  assign b_wdata = {nar_wdata, nar_wdata};

  spad_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_mem (
    .clk(clk),
    .a_en(a_en), .a_wr(a_wr), .a_idx(a_idx), .a_be(a_be), .a_wdata(a_wdata), .a_q(a_q),
    .b_en(nar_go), .b_wr(b_wr), .b_idx(b_idx), .b_be(b_be), .b_wdata(b_wdata), .b_q(b_q));

  // Response registers.
  logic        cpu_rv_q, cpu_err_q, dma_rv_q, dma_err_q, nar_rv_q, nar_odd_q;
  logic [3:0]  cpu_be_q, dma_be_q;
  logic [31:0] cpu_last_q, dma_last_q;
  logic [15:0] nar_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rv_q   <= 1'b0;
      cpu_err_q  <= 1'b0;
      dma_rv_q   <= 1'b0;
      dma_err_q  <= 1'b0;
      nar_rv_q   <= 1'b0;
      nar_odd_q  <= 1'b0;
      cpu_be_q   <= 4'b0;
      dma_be_q   <= 4'b0;
      cpu_last_q <= 32'b0;
      dma_last_q <= 32'b0;
      nar_last_q <= 16'b0;
    end else begin
      cpu_rv_q   <= cpu_rd_go;
      cpu_err_q  <= cpu_bad_ev;
      dma_rv_q   <= dma_rd_go;
      dma_err_q  <= dma_bad_ev;
      nar_rv_q   <= nar_go && !nar_we;
      if (cpu_rd_go) cpu_be_q <= cpu_be;
      if (dma_rd_go) dma_be_q <= dma_be;
      if (nar_go)    nar_odd_q <= nar_idx[0];
      cpu_last_q <= cpu_rdata;
      dma_last_q <= dma_rdata;
      nar_last_q <= nar_rdata;
    end
  end

  assign cpu_rvalid = cpu_rv_q;
  assign cpu_err    = cpu_err_q;
  assign dma_rvalid = dma_rv_q;
  assign dma_err    = dma_err_q;
  assign nar_rvalid = nar_rv_q;

  assign cpu_rdata = cpu_rv_q ? (a_q & lanes_to_bits(cpu_be_q)) : cpu_last_q;
  assign dma_rdata = dma_rv_q ? (a_q & lanes_to_bits(dma_be_q)) : dma_last_q;
  assign nar_rdata = nar_rv_q ? (nar_odd_q ? b_q[15:0] : b_q[31:16]) : nar_last_q;
endmodule

// File: rtl/spad_checker.sv
`timescale 1ns/1ps
module spad_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hold_i,
  input logic        nar_req,
  input logic        nar_we,
  input logic        nar_rvalid,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_hit,
  input logic        cpu_rvalid,
  input logic        cpu_err,
  input logic [31:0] cpu_rdata,
  input logic        dma_req,
  input logic        dma_stall,
  input logic        dma_rvalid,
  input logic        dma_err
);
  a_r1_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !hold_i && !cpu_hit) |=> (!cpu_rvalid && !cpu_err));

  a_r2_rvalid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_req && !cpu_we && !hold_i));

  a_r4_err_without_data: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> !cpu_rvalid);

  a_r5_stall_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stall |-> (cpu_req && dma_req && !hold_i));

  a_r6_stalled_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stall |=> (!dma_rvalid && !dma_err));

  a_r7_narrow_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_req && !nar_we && !hold_i) |=> nar_rvalid);

  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !(cpu_rvalid || dma_rvalid || nar_rvalid || cpu_err || dma_err));

  a_r11_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rvalid |-> $stable(cpu_rdata));
endmodule

bind scratchpad_bank spad_checker u_spad_chk (
  .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
  .nar_req(nar_req), .nar_we(nar_we), .nar_rvalid(nar_rvalid),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_hit(cpu_hit),
  .cpu_rvalid(cpu_rvalid), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
  .dma_req(dma_req), .dma_stall(dma_stall), .dma_rvalid(dma_rvalid), .dma_err(dma_err));

// File: tb/scratchpad_bank_bench.sv
`timescale 1ns/1ps
module scratchpad_bank_bench;
  localparam longint BASE  = 64'hFFFF8000;
  localparam int     BYTES = 4096;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, hold_i;
  logic        nar_req, nar_we, nar_rvalid;
  logic [10:0] nar_idx;
  logic [15:0] nar_wdata, nar_rdata;
  logic        cpu_req, cpu_we, cpu_rvalid, cpu_err;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        dma_req, dma_we, dma_stall, dma_rvalid, dma_err;
  logic [1:0]  dma_size;
  logic [31:0] dma_addr, dma_wdata, dma_rdata;

  scratchpad_bank u_scratchpad_bank (.*);

  int    checks = 0;
  int    errors = 0;
  string cur    = "init";

  logic [7:0]  ref_mem [BYTES];
  logic        e_crv, e_cerr, e_mrv, e_merr, e_nrv;
  logic [31:0] e_crd, e_mrd;
  logic [15:0] e_nrd;

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic in_win(input logic [31:0] a);
    longint v = longint'(a);
    return (v >= BASE) && (v < BASE + BYTES);
  endfunction

  function automatic int size_bytes(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int off, input int n);
    logic [31:0] v = 32'b0;
    for (int k = 0; k < n; k++) begin
      int p = (off % 4) + k;
      v[31-8*p -: 8] = ref_mem[off+k];
    end
    return v;
  endfunction

  task automatic model_write(input int off, input int n, input logic [31:0] d);
    for (int k = 0; k < n; k++) begin
      int p = (off % 4) + k;
      ref_mem[off+k] = d[31-8*p -: 8];
    end
  endtask

  task automatic idle_all();
    hold_i = 0;
    nar_req = 0; nar_we = 0; nar_idx = '0; nar_wdata = '0;
    cpu_req = 0; cpu_we = 0; cpu_size = 2'd2; cpu_addr = '0; cpu_wdata = '0;
    dma_req = 0; dma_we = 0; dma_size = 2'd2; dma_addr = '0; dma_wdata = '0;
  endtask

  task automatic cpu_op(input logic we, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic dma_op(input logic we, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    dma_req = 1; dma_we = we; dma_size = sz; dma_addr = a; dma_wdata = d;
  endtask

  task automatic nar_op(input logic we, input logic [10:0] i, input logic [15:0] d);
    nar_req = 1; nar_we = we; nar_idx = i; nar_wdata = d;
  endtask

  // One clock: predict, advance, compare.
  task automatic tick();
    logic ch, mh, stall, mg, cbad, mbad;
    int co, mo, cn, mn, no;
    logic [31:0] crd, mrd;
    logic [15:0] nrd;
    ch = cpu_req && !hold_i && in_win(cpu_addr);
    mh = dma_req && !hold_i && in_win(dma_addr);
    stall = ch && mh;
    mg = mh && !ch;
    co = int'(longint'(cpu_addr) - BASE);
    mo = int'(longint'(dma_addr) - BASE);
    cn = size_bytes(cpu_size);
    mn = size_bytes(dma_size);
    cbad = (cn == 0) || (ch && (co % cn) != 0);
    mbad = (mn == 0) || (mg && (mo % mn) != 0);
    no = int'(nar_idx) * 2;
    #1;
    check(cur, "dma_stall (R5)", {31'b0, dma_stall}, {31'b0, stall});
    // reads use contents before this cycle's writes (R9)
    crd = (ch && !cbad && !cpu_we) ? model_read(co, cn) : e_crd;
    mrd = (mg && !mbad && !dma_we) ? model_read(mo, mn) : e_mrd;
    nrd = (nar_req && !hold_i && !nar_we) ? {ref_mem[no], ref_mem[no+1]} : e_nrd;
    e_crv = ch && !cbad && !cpu_we;  e_cerr = ch && cbad;  e_crd = crd;
    e_mrv = mg && !mbad && !dma_we;  e_merr = mg && mbad;  e_mrd = mrd;
    e_nrv = nar_req && !hold_i && !nar_we; e_nrd = nrd;
    // wide write first, narrow last so it wins a same-byte clash (R8)
    if (ch && !cbad && cpu_we) model_write(co, cn, cpu_wdata);
    if (mg && !mbad && dma_we) model_write(mo, mn, dma_wdata);
    if (nar_req && !hold_i && nar_we) begin
      ref_mem[no]   = nar_wdata[15:8];
      ref_mem[no+1] = nar_wdata[7:0];
    end
    @(posedge clk);
    @(negedge clk);
    check(cur, "cpu_rvalid", {31'b0, cpu_rvalid}, {31'b0, e_crv});
    check(cur, "cpu_err",    {31'b0, cpu_err},    {31'b0, e_cerr});
    check(cur, "cpu_rdata",  cpu_rdata,           e_crd);
    check(cur, "dma_rvalid", {31'b0, dma_rvalid}, {31'b0, e_mrv});
    check(cur, "dma_err",    {31'b0, dma_err},    {31'b0, e_merr});
    check(cur, "dma_rdata",  dma_rdata,           e_mrd);
    check(cur, "nar_rvalid", {31'b0, nar_rvalid}, {31'b0, e_nrv});
    check(cur, "nar_rdata",  {16'b0, nar_rdata},  {16'b0, e_nrd});
    idle_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    check("R11", "reset cpu flags", {30'b0, cpu_rvalid, cpu_err}, 32'b0);
    check("R11", "reset dma flags", {30'b0, dma_rvalid, dma_err}, 32'b0);
    check("R11", "reset cpu_rdata", cpu_rdata, 32'b0);
    check("R11", "reset dma_rdata", dma_rdata, 32'b0);
    check("R11", "reset nar out",   {15'b0, nar_rvalid, nar_rdata}, 32'b0);
    e_crv = 0; e_cerr = 0; e_crd = '0;
    e_mrv = 0; e_merr = 0; e_mrd = '0;
    e_nrv = 0; e_nrd = '0;
    rst_n = 1;
  endtask

  // Watchdog: counts as a failed check and still prints the summary.
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [31:0] B = 32'hFFFF8000;

  initial begin
    idle_all();
    rst_n = 1;
    do_reset();

    cur = "init";
    for (int i = 0; i < BYTES / 4; i++) begin
      cpu_op(1, 2'd2, B + 32'(4*i), {16'(i) ^ 16'hA5C3, ~16'(i)});
      tick();
    end

    cur = "R2";
    cpu_op(1, 2'd2, B + 32'h10, 32'h11223344); tick();
    cpu_op(0, 2'd2, B + 32'h10, 0); tick();
    dma_op(0, 2'd2, B + 32'h10, 0); tick();

    cur = "R3";
    for (int p = 0; p < 4; p++) begin
      cpu_op(0, 2'd0, B + 32'h10 + 32'(p), 0); tick();
    end
    cpu_op(0, 2'd1, B + 32'h10, 0); tick();
    cpu_op(0, 2'd1, B + 32'h12, 0); tick();
    cpu_op(1, 2'd0, B + 32'h21, 32'h00AB0000); tick();
    cpu_op(1, 2'd1, B + 32'h26, 32'h0000BEEF); tick();
    dma_op(0, 2'd2, B + 32'h20, 0); tick();
    dma_op(0, 2'd2, B + 32'h24, 0); tick();

    cur = "R4";
    cpu_op(1, 2'd1, B + 32'h31, 32'hFFFFFFFF); tick();
    cpu_op(1, 2'd2, B + 32'h32, 32'hFFFFFFFF); tick();
    dma_op(1, 2'd3, B + 32'h30, 32'hFFFFFFFF); tick();
    cpu_op(0, 2'd2, B + 32'h30, 0); tick();

    cur = "R1";
    cpu_op(1, 2'd2, 32'hFFFF9000, 32'hDEADBEEF); tick();
    cpu_op(1, 2'd2, 32'hFFFF7FFC, 32'hDEADBEEF); tick();
    dma_op(0, 2'd2, 32'hFFFFA000, 0); tick();
    cpu_op(0, 2'd2, B, 0); tick();
    cpu_op(0, 2'd2, B + 32'hFFC, 0); tick();

    cur = "R5";
    cpu_op(1, 2'd2, B + 32'h40, 32'hC0C0C0C0);
    dma_op(1, 2'd2, B + 32'h44, 32'hD0D0D0D0); tick();
    cur = "R6";
    cpu_op(0, 2'd2, B + 32'h40, 0);
    dma_op(0, 2'd2, B + 32'h44, 0); tick();
    dma_op(0, 2'd2, B + 32'h44, 0); tick();

    cur = "R7";
    nar_op(1, 11'h40, 16'h1357);
    cpu_op(0, 2'd2, B + 32'h80, 0); tick();
    nar_op(1, 11'h41, 16'h2468); tick();
    nar_op(0, 11'h40, 0); cpu_op(0, 2'd2, B + 32'h80, 0); tick();
    nar_op(0, 11'h41, 0); tick();

    cur = "R8";
    cpu_op(1, 2'd2, B + 32'h90, 32'hAAAABBBB);
    nar_op(1, 11'h48, 16'h5A5A); tick();
    cpu_op(0, 2'd2, B + 32'h90, 0); tick();

    cur = "R9";
    cpu_op(0, 2'd2, B + 32'h94, 0);
    nar_op(1, 11'h4B, 16'h7777); tick();
    nar_op(0, 11'h4B, 0);
    dma_op(1, 2'd1, B + 32'h96, 32'h00001111); tick();
    cpu_op(0, 2'd2, B + 32'h94, 0); tick();

    cur = "R10";
    hold_i = 1;
    cpu_op(1, 2'd2, B + 32'hA0, 32'h99999999);
    nar_op(1, 11'h51, 16'h8888); tick();
    hold_i = 1;
    cpu_op(0, 2'd2, B + 32'hA0, 0);
    dma_op(0, 2'd2, B + 32'hA4, 0); tick();
    cpu_op(0, 2'd2, B + 32'hA0, 0); tick();

    cur = "R11";
    do_reset();
    cpu_op(0, 2'd2, B + 32'h10, 0); tick();
    tick();
    nar_op(0, 11'h48, 0); tick();

    cur = "random";
    for (int n = 0; n < 4000; n++) begin
      hold_i = ($urandom % 32) == 0;
      if ($urandom % 2) begin
        logic [1:0] sz = 2'($urandom % 4);
        logic [31:0] off = (($urandom % 3) == 0) ? 32'($urandom % 64) : 32'($urandom % 4096);
        if (($urandom % 8) != 0 && sz != 2'd3) off = off & ~32'(size_bytes(sz) - 1);
        cpu_op(1'($urandom), sz, (($urandom % 16) == 0) ? 32'hFFFF9000 + off : B + off, $urandom);
      end
      if ($urandom % 2) begin
        logic [1:0] sz = 2'($urandom % 4);
        logic [31:0] off = (($urandom % 3) == 0) ? 32'($urandom % 64) : 32'($urandom % 4096);
        if (($urandom % 8) != 0 && sz != 2'd3) off = off & ~32'(size_bytes(sz) - 1);
        dma_op(1'($urandom), sz, (($urandom % 16) == 0) ? 32'hFFFF7000 + off : B + off, $urandom);
      end
      if ($urandom % 2)
        nar_op(1'($urandom), (($urandom % 3) == 0) ? 11'($urandom % 32) : 11'($urandom), 16'($urandom));
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule